// File: doc/BRIEF.md
# Dual-Mode Packet CRC-16 Engine

This engine computes a 16-bit cyclic redundancy checksum over a byte stream in a packet radio data path. The framing logic upstream hands it every payload byte that follows the synchronisation word, together with valid, first-byte and final-byte strobes. One byte is folded into the checksum register in each clock cycle. The generator is x^16 + x^15 + x^2 + 1 (0x8005). The register is loaded with 0xFFFF at the start of each packet.

Two register structures can be selected. In the standard structure, each input bit is XORed with the register MSB, and the result forms the feedback. In the compatibility structure, the input bit shifts in at the LSB and the MSB alone drives the feedback. The compatibility structure finalises the checksum by pushing sixteen zero bits through the register. Packets are processed most significant bit first. Direction and structure are latched with the first byte of each packet.

When transmitting, the engine forwards each data byte one cycle later. It then appends the two checksum bytes, high byte first, and stalls its input while it does so. When receiving, it runs the data and the two received checksum bytes through the same register. One cycle after the final byte it reports done, and pass if the remaining value is zero. It also flags an illegal configuration: compatibility structure combined with whitening or with automatic flush on checksum error.

Top module: `crc16_pkt_engine`

## Requirements
- R1: In standard mode (mode_legacy_i = 0) the transmitted checksum equals the CRC with polynomial 0x8005 and preset 0xFFFF. Each data bit, MSB of each byte first, is XORed with register bit 15 to form the feedback. The ASCII bytes "123456789" give 0xAEE7.
- R2: In compatibility mode (mode_legacy_i = 1) each data bit shifts in at bit 0, and register bit 15 alone selects the XOR with 0x8005. After the final data byte, sixteen zero bits are clocked through before the checksum is emitted.
- R3: A byte accepted with in_sop_i = 1 starts a packet from preset 0xFFFF. While no packet is open, bytes without in_sop_i are ignored and produce no output.
- R4: On transmit, the checksum high byte appears on out_data_o two cycles after the final data byte is accepted, and the low byte one cycle after that. Both are marked by out_is_crc_o = 1 with out_valid_o = 1, and they follow the final data byte with no gap.
- R5: For the two cycles after a transmit final byte is accepted, in_ready_o is 0, and any byte offered in those cycles is dropped.
- R6: On receive (dir_tx_i = 0 at packet start), crc_done_o pulses for one cycle on the cycle after the final byte is accepted. crc_ok_o is 1 in that cycle exactly when the register is zero after the data and both checksum bytes have been processed.
- R7: mode_legacy_i and dir_tx_i are taken from the first byte of a packet, and later changes within that packet have no effect.
- R8: config_error_o is 1 exactly when mode_legacy_i = 1 and at least one of whiten_en_i or autoflush_en_i is 1.
- R9: On transmit, each accepted data byte appears on out_data_o with out_valid_o = 1 and out_is_crc_o = 0 on the following cycle. On receive, out_valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_legacy_i | input | 1 | 1 selects the compatibility register structure (latched at packet start) |
| dir_tx_i | input | 1 | 1 for transmit, 0 for receive (latched at packet start) |
| whiten_en_i | input | 1 | Whitening enabled in the data path |
| autoflush_en_i | input | 1 | Automatic flush on checksum error enabled |
| in_valid_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | First byte after the synchronisation word |
| in_last_i | input | 1 | Final byte of the packet |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Engine can take a byte |
| out_valid_o | output | 1 | Output byte valid (transmit) |
| out_data_o | output | 8 | Forwarded data or checksum byte |
| out_is_crc_o | output | 1 | Output byte is part of the checksum |
| crc_done_o | output | 1 | Receive check complete (one-cycle pulse) |
| crc_ok_o | output | 1 | Receive checksum passed, valid with crc_done_o |
| config_error_o | output | 1 | Illegal mode combination |

## Verification
The hardest situation to reach is a mode or direction change in the middle of a packet that the engine must ignore. The same applies to a byte that arrives during the two stall cycles of a checksum append. Both must leave the emitted checksum unchanged. The stimulus toggles mode_legacy_i and dir_tx_i at random on every byte after the first. During the append cycles it keeps in_valid_i high with a start strobe and a stray byte. It then checks that the checksum still matches a bench model that used the packet's first-byte settings, and that the stray byte never appears. Random packets also insert idle gaps, and receive packets with a single-bit error at a random position exercise the failing residual.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_APP_HI,
    ST_APP_LO
  } eng_state_e;
endpackage

// File: rtl/crc16_byte_step.sv
// One byte of CRC update, MSB first, unrolled over BW bits.
module crc16_byte_step #(
  parameter int unsigned CW = crc16_pkg::CRC_W,
  parameter int unsigned BW = crc16_pkg::BYTE_W,
  parameter logic [CW-1:0] POLY = crc16_pkg::CRC_POLY
) (
  input  logic [CW-1:0] crc_i,
  input  logic [BW-1:0] data_i,
  input  logic          legacy_i,
  output logic [CW-1:0] crc_o
);
  logic [BW:0][CW-1:0] chain;

  assign chain[0] = crc_i;

  for (genvar b = 0; b < BW; b++) begin : g_bit
    logic          din;
    logic          fb;
    logic [CW-1:0] shifted;
    assign din     = data_i[BW-1-b];
    // standard: data mixes into feedback at the top; legacy: data enters at bit 0
    assign fb      = legacy_i ? chain[b][CW-1] : (chain[b][CW-1] ^ din);
    assign shifted = {chain[b][CW-2:0], legacy_i & din};
    assign chain[b+1] = shifted ^ (fb ? POLY : '0);
  end

  assign crc_o = chain[BW];
endmodule

// File: rtl/crc16_pkt_ctrl.sv
module crc16_pkt_ctrl
  import crc16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic       in_last_i,
  input  logic       tx_eff_i,
  output logic       accept_o,
  output logic       ready_o,
  output eng_state_e state_o
);
  eng_state_e state_q, state_d;

  assign ready_o  = (state_q == ST_IDLE) || (state_q == ST_RUN);
  assign accept_o = in_valid_i && ready_o && (in_sop_i || (state_q == ST_RUN));
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_RUN: begin
        if (accept_o) begin
          if (in_last_i) state_d = tx_eff_i ? ST_APP_HI : ST_IDLE;
          else           state_d = ST_RUN;
        end
      end
      ST_APP_HI: state_d = ST_APP_LO;
      ST_APP_LO: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/crc16_pkt_engine.sv
module crc16_pkt_engine
  import crc16_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_legacy_i,
  input  logic              dir_tx_i,
  input  logic              whiten_en_i,
  input  logic              autoflush_en_i,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_last_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_is_crc_o,
  output logic              crc_done_o,
  output logic              crc_ok_o,
  output logic              config_error_o
);
  localparam int unsigned HALF = CRC_W / 2;

  eng_state_e        state;
  logic              accept;
  logic              tx_q, leg_q, tx_eff, leg_eff, is_app;
  logic [CRC_W-1:0]  crc_q, seed, step_d, step_z1, step_z2;
  logic              out_valid_q, out_crc_q, done_q, ok_q;
  logic [BYTE_W-1:0] out_data_q;

  // mode and direction come from the first byte, then are held
  assign tx_eff  = in_sop_i ? dir_tx_i : tx_q;
  assign leg_eff = in_sop_i ? mode_legacy_i : leg_q;
  assign seed    = in_sop_i ? CRC_INIT : crc_q;
  assign is_app  = (state == ST_APP_HI) || (state == ST_APP_LO);

  crc16_pkt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(in_valid_i),
    .in_sop_i  (in_sop_i),
    .in_last_i (in_last_i),
    .tx_eff_i  (tx_eff),
    .accept_o  (accept),
    .ready_o   (in_ready_o),
    .state_o   (state)
  );

  crc16_byte_step u_step_data (
    .crc_i(seed), .data_i(in_data_i), .legacy_i(leg_eff), .crc_o(step_d)
  );
  // legacy finalisation: 16 zero bits as two zero bytes
  crc16_byte_step u_step_z1 (
    .crc_i(step_d), .data_i('0), .legacy_i(1'b1), .crc_o(step_z1)
  );
  crc16_byte_step u_step_z2 (
    .crc_i(step_z1), .data_i('0), .legacy_i(1'b1), .crc_o(step_z2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q       <= CRC_INIT;
      tx_q        <= 1'b0;
      leg_q       <= 1'b0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_crc_q   <= 1'b0;
      done_q      <= 1'b0;
      ok_q        <= 1'b0;
    end else begin
      done_q      <= accept && in_last_i && !tx_eff;
      ok_q        <= accept && in_last_i && !tx_eff && (step_d == '0);
      out_valid_q <= (accept && tx_eff) || is_app;
      out_crc_q   <= is_app;
      if (accept) begin
        out_data_q <= in_data_i;
        crc_q      <= (in_last_i && tx_eff && leg_eff) ? step_z2 : step_d;
        if (in_sop_i) begin
          tx_q  <= dir_tx_i;
          leg_q <= mode_legacy_i;
        end
      end else if (state == ST_APP_HI) begin
        out_data_q <= crc_q[CRC_W-1:HALF];
      end else if (state == ST_APP_LO) begin
        out_data_q <= crc_q[HALF-1:0];
      end
    end
  end

  assign out_valid_o    = out_valid_q;
  assign out_data_o     = out_data_q;
  assign out_is_crc_o   = out_crc_q;
  assign crc_done_o     = done_q;
  assign crc_ok_o       = ok_q;
  assign config_error_o = mode_legacy_i && (whiten_en_i || autoflush_en_i);
endmodule

// File: rtl/crc16_pkt_engine_chk.sv
module crc16_pkt_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic accept_i,
  input logic tx_eff_i,
  input logic in_last_i,
  input logic in_ready_i,
  input logic out_valid_i,
  input logic out_is_crc_i,
  input logic crc_done_i,
  input logic crc_ok_i
);
  // R5
  tx_last_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && in_last_i && tx_eff_i) |=> (!in_ready_i && out_valid_i && !out_is_crc_i));

  // R5
  stall_then_crc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_i |=> out_is_crc_i);

  // R4
  crc_tag_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_is_crc_i |-> out_valid_i);

  // R4
  crc_two_bytes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_is_crc_i && $past(out_is_crc_i)) |=> !out_is_crc_i);

  // R6
  ok_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_ok_i |-> crc_done_i);

  // R6
  rx_done_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && in_last_i && !tx_eff_i) |=> crc_done_i);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_done_i |=> !crc_done_i || $past(accept_i && in_last_i && !tx_eff_i));
endmodule

bind crc16_pkt_engine crc16_pkt_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .accept_i    (accept),
  .tx_eff_i    (tx_eff),
  .in_last_i   (in_last_i),
  .in_ready_i  (in_ready_o),
  .out_valid_i (out_valid_o),
  .out_is_crc_i(out_is_crc_o),
  .crc_done_i  (crc_done_o),
  .crc_ok_i    (crc_ok_o)
);

// File: tb/crc16_pkt_engine_tb_top.sv
module crc16_pkt_engine_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_legacy, dir_tx, whiten_en, autoflush_en;
  logic       in_valid, in_sop, in_last;
  logic [7:0] in_data;
  logic       in_ready, out_valid, out_is_crc, crc_done, crc_ok, config_error;
  logic [7:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0]  dat [0:40];
  logic [15:0] got_fcs;

  always #(CLK_P/2) clk = ~clk;

  crc16_pkt_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_legacy_i(mode_legacy), .dir_tx_i(dir_tx),
    .whiten_en_i(whiten_en), .autoflush_en_i(autoflush_en),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_last_i(in_last), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_is_crc_o(out_is_crc), .crc_done_o(crc_done), .crc_ok_o(crc_ok),
    .config_error_o(config_error)
  );

  function automatic logic [15:0] m_norm(logic [15:0] c, logic [7:0] d);
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = c[15] ^ d[k];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  function automatic logic [15:0] m_leg(logic [15:0] c, logic [7:0] d);
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = c[15];
      c  = {c[14:0], d[k]};
      if (fb) c = c ^ 16'h8005;
    end
    return c;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0; in_data = 8'h00;
  endtask

  // dat[0..len-1] holds the payload; gaps and mid-packet mode noise are random
  task automatic run_pkt(bit tx, bit leg, int len, bit corrupt);
    logic [15:0] fcs;
    int total;
    fcs = 16'hFFFF;
    for (int i = 0; i < len; i++) fcs = leg ? m_leg(fcs, dat[i]) : m_norm(fcs, dat[i]);
    if (leg) begin
      fcs = m_leg(fcs, 8'h00);
      fcs = m_leg(fcs, 8'h00);
    end
    total = len;
    if (!tx) begin
      dat[len]     = fcs[15:8];
      dat[len + 1] = fcs[7:0];
      total = len + 2;
      if (corrupt) begin
        int p;
        p = int'($urandom % total);
        dat[p] = dat[p] ^ (8'h01 << ($urandom % 8));
      end
    end
    for (int i = 0; i < total; i++) begin
      if (i != 0 && ($urandom % 5) == 0) begin
        idle_inputs();
        @(negedge clk);
        chk("R9", "gap out_valid", out_valid, 0);
      end
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_last  = (i == total - 1);
      in_data  = dat[i];
      // R7: noise on mode and direction after the first byte
      mode_legacy = (i == 0) ? leg : 1'($urandom);
      dir_tx      = (i == 0) ? tx  : 1'($urandom);
      @(negedge clk);
      if (tx) begin
        chk("R9", "data out_valid", out_valid, 1);
        chk("R9", "data byte", out_data, dat[i]);
        chk("R9", "data tag", out_is_crc, 0);
      end else begin
        chk("R9", "rx out_valid", out_valid, 0);
        if (i == total - 1) begin
          chk("R6", "crc_done", crc_done, 1);
          chk("R6", "crc_ok", crc_ok, corrupt ? 0 : 1);
        end else begin
          chk("R6", "early done", crc_done, 0);
        end
      end
    end
    if (tx) begin
      chk("R5", "ready after last", in_ready, 0);
      // R5: stray start byte offered during the stall
      in_valid = 1'b1; in_sop = 1'b1; in_last = 1'b1; in_data = 8'h5A;
      @(negedge clk);
      chk("R4", "hi valid", out_valid, 1);
      chk("R4", "hi tag", out_is_crc, 1);
      chk(leg ? "R2" : "R1", "fcs hi", out_data, fcs[15:8]);
      chk("R5", "ready in append", in_ready, 0);
      got_fcs[15:8] = out_data;
      @(negedge clk);
      chk("R4", "lo tag", out_is_crc, 1);
      chk(leg ? "R2" : "R1", "fcs lo", out_data, fcs[7:0]);
      chk("R5", "ready restored", in_ready, 1);
      got_fcs[7:0] = out_data;
      idle_inputs();
      @(negedge clk);
      chk("R5", "stray byte dropped", out_valid, 0);
    end else begin
      idle_inputs();
      @(negedge clk);
      chk("R6", "done pulse ends", crc_done, 0);
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    mode_legacy = 1'b0; dir_tx = 1'b1; whiten_en = 1'b0; autoflush_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "reset out_valid", out_valid, 0);
    chk("R6", "reset done", crc_done, 0);
    chk("R5", "reset ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: bytes with no open packet are ignored
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_sop = 1'b0; in_last = (i == 2); in_data = 8'hC3 + 8'(i);
      @(negedge clk);
      chk("R3", "no sop ignored", out_valid, 0);
    end
    idle_inputs();
    @(negedge clk);

    // R1 known vector
    for (int i = 0; i < 9; i++) dat[i] = 8'h31 + 8'(i);
    run_pkt(1'b1, 1'b0, 9, 1'b0);
    chk("R1", "check value 123456789", got_fcs, 16'hAEE7);
    chk("R3", "preset on restart", got_fcs, 16'hAEE7);
    for (int i = 0; i < 9; i++) dat[i] = 8'h31 + 8'(i);
    run_pkt(1'b1, 1'b0, 9, 1'b0);
    chk("R3", "second packet same fcs", got_fcs, 16'hAEE7);

    // R2 directed: single byte and all-zero payload in legacy mode
    dat[0] = 8'h00;
    run_pkt(1'b1, 1'b1, 1, 1'b0);
    for (int i = 0; i < 4; i++) dat[i] = 8'hFF;
    run_pkt(1'b1, 1'b1, 4, 1'b0);
    dat[0] = 8'hA5;
    run_pkt(1'b0, 1'b1, 1, 1'b0);
    dat[0] = 8'hA5;
    run_pkt(1'b0, 1'b0, 1, 1'b1);

    // R8 configuration error
    idle_inputs();
    for (int m = 0; m < 8; m++) begin
      mode_legacy = m[2]; whiten_en = m[1]; autoflush_en = m[0];
      #1;
      chk("R8", "config_error", config_error, (m[2] && (m[1] || m[0])) ? 1 : 0);
    end
    mode_legacy = 1'b0; whiten_en = 1'b0; autoflush_en = 1'b0;
    @(negedge clk);

    // random packets
    for (int p = 0; p < 300; p++) begin
      int len;
      len = 1 + int'($urandom % 32);
      for (int i = 0; i < len; i++) dat[i] = 8'($urandom);
      run_pkt(1'($urandom), 1'($urandom), len, (($urandom % 3) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule